// File: doc/BRIEF.md
# I2C Controller Interrupt Event Unit

This block gathers the event sources of a multimaster I2C controller into a vector of sticky status flags. It also drives one masked, registered interrupt line. The bus engine feeds it single-cycle event pulses: lost arbitration, a received not-acknowledge, a general-call address, a start seen while idle, a start or stop seen as a slave, and receive or transmit FIFO service requests. The engine also supplies the live byte counter and the RX FIFO empty flag.

The unit owns three mode control bits: stop request, master and transmit direction. Software writes them through a small register port, and the same port reads the status flags, clears them and sets their enables. When a not-acknowledge arrives in master mode, the unit clears all three control bits on its own, which puts the controller back in slave-receiver mode. It also issues a one-cycle stop-generation request to the bus engine. The access-ready flag is decided inside the unit from the mode, the byte counter, the stop request and FIFO emptiness.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, the status flags, the enables, the control bits, irq_o and stop_gen_o are all 0.
- R2: Each status bit has a fixed position: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, general call 5, start while idle 6. A bit stays set until software writes 1 to that bit at register address 0. Writing 0 to a bit leaves it unchanged.
- R3: ev_arb_lost sets bit 0 only while the master control bit is 1. The pulse is ignored otherwise.
- R4: An ev_nack pulse sets bit 1. If the master control bit is 1 in that cycle, the next cycle shows stop, master and transmit cleared and stop_gen_o high for exactly one cycle. This holds even if software writes the control register in the same cycle.
- R5: In master-receive mode (master 1, transmit 0), access ready is set in the first cycle in which stop request is 1, the byte count is 0 and the RX FIFO is empty.
- R6: In master-transmit mode (master 1, transmit 1), access ready is set in the first cycle in which the byte count is 0, whether or not stop is requested.
- R7: With master 0, ev_slv_bus_cond sets access ready if the transmit bit is 1. If the transmit bit is 0, it sets access ready only when the RX FIFO is also empty.
- R8: ev_rx_ready, ev_tx_ready, ev_gen_call and ev_start_idle set bits 3, 4, 5 and 6 respectively.
- R9: irq_o equals the OR over all bits of status AND enable, as they stood one cycle earlier.
- R10: If an event and a software clear hit the same bit in one cycle, the bit ends up set.
- R11: Register address 1 holds the enable bits, at the same positions as the status bits. Address 2 holds the control bits: stop at bit 0, master at bit 1, transmit at bit 2. Both read back what was written, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | NACK received pulse |
| ev_gen_call | input | 1 | All-zero address received pulse |
| ev_start_idle | input | 1 | Start detected while idle pulse |
| ev_slv_bus_cond | input | 1 | Start or stop received as slave pulse |
| ev_rx_ready | input | 1 | RX FIFO above threshold pulse |
| ev_tx_ready | input | 1 | TX FIFO needs data pulse |
| byte_cnt | input | 16 | Remaining byte count |
| rx_empty | input | 1 | RX FIFO empty |
| status_o | output | 7 | Status flags |
| irq_o | output | 1 | Registered interrupt |
| ctl_stop_o | output | 1 | Stop request control bit |
| ctl_master_o | output | 1 | Master control bit |
| ctl_trx_o | output | 1 | Transmit direction control bit |
| stop_gen_o | output | 1 | One-cycle stop generation request |

## Verification
The bench targets five corner cases.

- Arbitration loss in slave mode must not set bit 0. A design that did not qualify ev_arb_lost with the master bit would raise a spurious interrupt.
- A NACK must take priority over a software control write landing in the same cycle. If the priority were wrong, the controller would stay in master mode after the transfer ended.
- A master-receive count that reaches zero while the FIFO still holds data must not set access ready until the FIFO drains. A design that fired early, or that fired again on every cycle the condition held, would break the edge-based rule.
- A slave-receive start or stop with a non-empty FIFO must leave access ready clear.
- An event arriving in the same cycle as its own clear must leave the bit set. Losing it would silently drop an interrupt.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NSTS      = 7;
    localparam int B_ARB     = 0;
    localparam int B_NACK    = 1;
    localparam int B_ARDY    = 2;
    localparam int B_RRDY    = 3;
    localparam int B_XRDY    = 4;
    localparam int B_GC      = 5;
    localparam int B_STIDLE  = 6;
    localparam int C_STOP    = 0;
    localparam int C_MST     = 1;
    localparam int C_TRX     = 2;
    localparam int NCTL      = 3;
    localparam logic [1:0] A_STATUS = 2'd0;
    localparam logic [1:0] A_ENABLE = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NCTL-1:0] wdata_i,
    input  logic            nack_i,
    output logic            stop_o,
    output logic            master_o,
    output logic            trx_o,
    output logic            stop_gen_o
);
    typedef struct packed {
        logic [NCTL-1:0] ctl;
        logic            sgen;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sgen = 1'b0;
        if (wr_i) st_d.ctl = wdata_i;
        if (nack_i && st_q.ctl[C_MST]) begin
            st_d.ctl  = '0;
            st_d.sgen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stop_o     = st_q.ctl[C_STOP];
    assign master_o   = st_q.ctl[C_MST];
    assign trx_o      = st_q.ctl[C_TRX];
    assign stop_gen_o = st_q.sgen;

    AST_NACK_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_i && master_o) |=> (!master_o && !trx_o && !stop_o && stop_gen_o)); // R4
    AST_SGEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_gen_o |=> !stop_gen_o); // R4
endmodule

// File: rtl/i2c_irq_ardy.sv
module i2c_irq_ardy #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic             trx_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic             rx_empty_i,
    input  logic             slv_cond_i,
    output logic             set_o
);
    typedef struct packed {
        logic prev;
    } ardy_t;

    ardy_t st_d, st_q;
    logic  cnt_zero, mst_cond, slv_set;

    always_comb begin
        cnt_zero = (byte_cnt_i == '0);
        mst_cond = master_i && cnt_zero && (trx_i || (stop_i && rx_empty_i));
        slv_set  = !master_i && slv_cond_i && (trx_i || rx_empty_i);
        st_d      = st_q;
        st_d.prev = mst_cond;
        set_o     = (mst_cond && !st_q.prev) || slv_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SLV_RX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !trx_i && !rx_empty_i && slv_cond_i) |-> !slv_set); // R7
    AST_MRX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && !trx_i && !rx_empty_i) |-> !mst_cond); // R5
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_wr_i,
    input  logic [N-1:0] en_wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] enable_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] sts;
        logic [N-1:0] en;
        logic         irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (st_q.sts & ~clr_i) | set_i;
        if (en_wr_i) st_d.en = en_wdata_i;
        st_d.irq = |(st_q.sts & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.sts;
    assign enable_o = st_q.en;
    assign irq_o    = st_q.irq;

    AST_STICKY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o))); // R2
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R10
    AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_o & enable_o)))); // R9
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             ev_arb_lost,
    input  logic             ev_nack,
    input  logic             ev_gen_call,
    input  logic             ev_start_idle,
    input  logic             ev_slv_bus_cond,
    input  logic             ev_rx_ready,
    input  logic             ev_tx_ready,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             rx_empty,
    output logic [NSTS-1:0]  status_o,
    output logic             irq_o,
    output logic             ctl_stop_o,
    output logic             ctl_master_o,
    output logic             ctl_trx_o,
    output logic             stop_gen_o
);
    logic [NSTS-1:0] set_vec, clr_vec, enable;
    logic            ardy_set, wr_sts, wr_en, wr_ctl;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:NSTS];
    assign wr_sts = reg_wr && (reg_addr == A_STATUS);
    assign wr_en  = reg_wr && (reg_addr == A_ENABLE);
    assign wr_ctl = reg_wr && (reg_addr == A_CTRL);
    assign clr_vec = wr_sts ? reg_wdata[NSTS-1:0] : '0;

    i2c_irq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctl), .wdata_i(reg_wdata[NCTL-1:0]),
        .nack_i(ev_nack), .stop_o(ctl_stop_o), .master_o(ctl_master_o),
        .trx_o(ctl_trx_o), .stop_gen_o(stop_gen_o)
    );

    i2c_irq_ardy #(.CNT_W(CNT_W)) u_ardy (
        .clk(clk), .rst_n(rst_n), .master_i(ctl_master_o), .trx_i(ctl_trx_o),
        .stop_i(ctl_stop_o), .byte_cnt_i(byte_cnt), .rx_empty_i(rx_empty),
        .slv_cond_i(ev_slv_bus_cond), .set_o(ardy_set)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[B_ARB]    = ev_arb_lost && ctl_master_o;
        set_vec[B_NACK]   = ev_nack;
        set_vec[B_ARDY]   = ardy_set;
        set_vec[B_RRDY]   = ev_rx_ready;
        set_vec[B_XRDY]   = ev_tx_ready;
        set_vec[B_GC]     = ev_gen_call;
        set_vec[B_STIDLE] = ev_start_idle;
    end

    i2c_irq_status #(.N(NSTS)) u_sts (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
        .en_wr_i(wr_en), .en_wdata_i(reg_wdata[NSTS-1:0]),
        .status_o(status_o), .enable_o(enable), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata[NSTS-1:0] = status_o;
            A_ENABLE: reg_rdata[NSTS-1:0] = enable;
            A_CTRL:   reg_rdata[NCTL-1:0] = {ctl_trx_o, ctl_master_o, ctl_stop_o};
            default:  reg_rdata = '0;
        endcase
    end

    AST_ARB_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_master_o && !status_o[B_ARB] && !wr_sts) |=> !status_o[B_ARB]); // R3
endmodule

// File: tb/tb_i2c_irq_unit.sv
module tb_i2c_irq_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic ev_arb_lost = 0, ev_nack = 0, ev_gen_call = 0, ev_start_idle = 0;
    logic ev_slv_bus_cond = 0, ev_rx_ready = 0, ev_tx_ready = 0;
    logic [15:0] byte_cnt = 16'd1;
    logic rx_empty = 1'b1;
    logic [6:0] status_o;
    logic irq_o, ctl_stop_o, ctl_master_o, ctl_trx_o, stop_gen_o;

    always #4 clk = ~clk;

    i2c_irq_unit dut (.*);

    int vectors = 0, errors = 0;
    string cur_req = "R1";
    int m_sts = 0, m_en = 0, m_ctl = 0, m_prev = 0, m_irq = 0, m_sg = 0;

    task automatic chk(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_sts;
            1: return m_en;
            2: return m_ctl;
            default: return 0;
        endcase
    endfunction

    task automatic cyc();
        int mst, trx, stp, cond, set, clr, n_ctl;
        #1;
        chk("rdata", int'(reg_rdata), model_read(int'(reg_addr)));
        mst = (m_ctl >> 1) & 1; trx = (m_ctl >> 2) & 1; stp = m_ctl & 1;
        cond = mst && byte_cnt == 0 && (trx || (stp && rx_empty));
        set = 0;
        if (ev_arb_lost && mst) set |= 1;
        if (ev_nack) set |= 2;
        if (cond && !m_prev) set |= 4;
        if (!mst && ev_slv_bus_cond && (trx || rx_empty)) set |= 4;
        if (ev_rx_ready) set |= 8;
        if (ev_tx_ready) set |= 16;
        if (ev_gen_call) set |= 32;
        if (ev_start_idle) set |= 64;
        clr = (reg_wr && reg_addr == 0) ? (int'(reg_wdata) & 127) : 0;
        n_ctl = (reg_wr && reg_addr == 2) ? (int'(reg_wdata) & 7) : m_ctl;
        if (ev_nack && mst) n_ctl = 0;
        @(posedge clk);
        m_irq  = ((m_sts & m_en) != 0);
        m_sg   = ev_nack && mst;
        if (reg_wr && reg_addr == 1) m_en = int'(reg_wdata) & 127;
        m_sts  = (m_sts & ~clr) | set;
        m_ctl  = n_ctl;
        m_prev = cond;
        @(negedge clk);
        chk("status", int'(status_o), m_sts);
        chk("irq", int'(irq_o), m_irq);
        chk("ctrl", int'({ctl_trx_o, ctl_master_o, ctl_stop_o}), m_ctl);
        chk("stop_gen", int'(stop_gen_o), m_sg);
        reg_wr = 0; ev_arb_lost = 0; ev_nack = 0; ev_gen_call = 0;
        ev_start_idle = 0; ev_slv_bus_cond = 0; ev_rx_ready = 0; ev_tx_ready = 0;
    endtask

    task automatic wr(input int a, input int d);
        reg_wr = 1; reg_addr = 2'(a); reg_wdata = 16'(d);
        cyc();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        chk("reset status", int'(status_o), 0);
        chk("reset irq", int'(irq_o), 0);
        chk("reset ctrl", int'({ctl_trx_o, ctl_master_o, ctl_stop_o}), 0);
        chk("reset stop_gen", int'(stop_gen_o), 0);
        cur_req = "R11";
        wr(1, 'h5A); reg_addr = 1; cyc();
        wr(2, 6); reg_addr = 2; cyc();
        reg_addr = 3; cyc();
        wr(2, 0);
        cur_req = "R3";
        ev_arb_lost = 1; cyc();
        wr(2, 2); ev_arb_lost = 1; cyc();
        cur_req = "R8";
        ev_rx_ready = 1; cyc(); ev_tx_ready = 1; cyc();
        ev_gen_call = 1; cyc(); ev_start_idle = 1; cyc();
        cur_req = "R9";
        wr(1, 'h7F); reg_addr = 0; cyc(); cyc();
        cur_req = "R2";
        wr(0, 0); wr(0, 'h41); reg_addr = 0; cyc();
        cur_req = "R10";
        reg_wr = 1; reg_addr = 0; reg_wdata = 16'h7F; ev_gen_call = 1; cyc();
        reg_addr = 0; cyc();
        wr(0, 'h7F);
        cur_req = "R5";
        byte_cnt = 5; rx_empty = 0; wr(2, 3); cyc();
        byte_cnt = 0; cyc(); cyc();
        rx_empty = 1; cyc(); cyc();
        wr(0, 'h7F); cyc();
        cur_req = "R6";
        byte_cnt = 3; wr(2, 6); cyc();
        byte_cnt = 0; cyc(); cyc();
        cur_req = "R7";
        wr(2, 4); wr(0, 'h7F); ev_slv_bus_cond = 1; rx_empty = 0; cyc();
        wr(2, 0); wr(0, 'h7F); ev_slv_bus_cond = 1; cyc();
        rx_empty = 1; ev_slv_bus_cond = 1; cyc();
        cur_req = "R4";
        wr(2, 7); ev_nack = 1; cyc(); cyc();
        wr(2, 7); reg_wr = 1; reg_addr = 2; reg_wdata = 7; ev_nack = 1; cyc(); cyc();
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_addr = 2'($urandom_range(0, 3));
            reg_wdata = 16'($urandom);
            ev_arb_lost = ($urandom_range(0, 7) == 0);
            ev_nack = ($urandom_range(0, 15) == 0);
            ev_gen_call = ($urandom_range(0, 15) == 0);
            ev_start_idle = ($urandom_range(0, 15) == 0);
            ev_slv_bus_cond = ($urandom_range(0, 7) == 0);
            ev_rx_ready = ($urandom_range(0, 7) == 0);
            ev_tx_ready = ($urandom_range(0, 7) == 0);
            byte_cnt = ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(1, 4));
            rx_empty = 1'($urandom);
            cyc();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule